// File: doc/BRIEF.md
# Integrating ADC Sequence Controller

This block is the digital sequencer for a dual-slope style integrating analog-to-digital converter. A one-hot phase register walks the conversion through reset, signal integration, bias, two reference de-integration phases and a short store phase, then back to reset. Each phase drives a 3-bit code onto the analog control lines. It leaves a phase only when that phase reports that it is complete. The signal and bias phases have fixed, parameterised lengths. The reference phases are ended by the null-detect comparator.

A host processor writes two registers. The delay preset holds off the next conversion so the analog front end can settle. The control register selects the counter resolution and the trigger source. A control write also clears the processor command latch, the data-ready flag and the overrange flag. The main counter counts every clock spent in the two reference phases. At the end of a reading the block raises data-ready, and the host reads the count with a strobe that clears the flag. The design expects an 800 kHz timebase on `clk`, but nothing in it depends on the frequency.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Exactly one bit of `phase_oh` is high at all times. Synchronous reset forces the reset phase (bit 0) and clears `count`, `data_ready` and `overrange`.
- R2: Phases run in the order reset (bit 0), signal (bit 1), bias (bit 2), reference 1 (bit 3), reference 2 (bit 4), store (bit 5), reset. A phase changes only when the current phase completes. Bits 6 and 7 stay low.
- R3: `ana_code` is 000 in reset, 001 in signal, 010 in bias, 011 in reference 1, 100 in reference 2, and 111 otherwise.
- R4: The signal phase lasts exactly SIG_CYC clocks and the bias phase exactly BIAS_CYC clocks.
- R5: `count` is cleared when a conversion starts. It then increments once per clock spent in reference 1 and reference 2. Reference 1 ends on the clock that samples `null_det` high and moves to reference 2. Reference 2 ends the same way and moves to store.
- R6: A write with `wr_sel`=0 loads `wr_data` into the delay counter. The counter decrements once per clock in the reset phase. No conversion starts while it is non-zero.
- R7: Control bits [3:2] select the start source: 0 `trig_int`, 1 `trig_ext`, 2 processor command latch, 3 none. A conversion starts on the clock where the phase is reset, the delay is zero and the selected source is high. Unselected sources have no effect.
- R8: A `trig_cpu` pulse sets the command latch. Starting a conversion from that latch clears it, and so does a control write (`wr_sel`=1).
- R9: `data_ready` rises on the clock that leaves the store phase. A `rd_count` strobe or a control write clears it.
- R10: Control bits [1:0] select a terminal count of 2^16-1 (0), 2^18-1 (1) or 2^20-1 (2 or 3). When a reference phase reaches that count, `count` holds at it, `overrange` sets and the sequence jumps to store. A control write or the start of a conversion clears `overrange`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Processor register write strobe |
| wr_sel | input | 1 | 0 = delay preset, 1 = control register |
| wr_data | input | DATA_W | Processor write data |
| rd_count | input | 1 | Count read strobe, clears data-ready |
| trig_int | input | 1 | Internal trigger |
| trig_ext | input | 1 | External trigger |
| trig_cpu | input | 1 | Processor trigger pulse, sets command latch |
| null_det | input | 1 | Comparator null detect |
| phase_oh | output | 8 | One-hot phase outputs |
| ana_code | output | 3 | Analog control code |
| count | output | RES_BASE+4 | Main counter |
| data_ready | output | 1 | Reading complete flag |
| overrange | output | 1 | Count saturated flag |

## Verification
If the phase register goes wrong, it shows on `phase_oh` and `ana_code` in the same cycle: a skipped, repeated or doubled phase is visible at once. A wrong phase timer changes the number of clocks the signal or bias code is held, so the error is seen when that phase ends. Errors in count gating or null handling appear only once data-ready rises, as a count that differs from the number of reference clocks. Errors in the delay or trigger gating appear as a start that comes early, late or never after the stimulus.

// File: rtl/adc_seq_pkg.sv
// Shared constants for the integrating ADC sequencer.
// Assumes eight one-hot phase outputs, of which six are used.
package adc_seq_pkg;
    localparam int NPH      = 8;
    localparam int PH_RST   = 0;
    localparam int PH_SIG   = 1;
    localparam int PH_BIAS  = 2;
    localparam int PH_REF1  = 3;
    localparam int PH_REF2  = 4;
    localparam int PH_STORE = 5;

    localparam logic [2:0] CODE_RST  = 3'b000;
    localparam logic [2:0] CODE_SIG  = 3'b001;
    localparam logic [2:0] CODE_BIAS = 3'b010;
    localparam logic [2:0] CODE_REF1 = 3'b011;
    localparam logic [2:0] CODE_REF2 = 3'b100;
    localparam logic [2:0] CODE_IDLE = 3'b111;

    typedef enum logic [1:0] {
        TRG_INT  = 2'd0,
        TRG_EXT  = 2'd1,
        TRG_CPU  = 2'd2,
        TRG_NONE = 2'd3
    } trig_sel_e;
endpackage

// File: rtl/adc_phase_seq.sv
// One-hot phase sequencer with fixed-length phase timer and analog code decode.
// Assumes start, null_det and sat are synchronous to clk.
module adc_phase_seq
    import adc_seq_pkg::*;
#(
    parameter int SIG_CYC  = 40,
    parameter int BIAS_CYC = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           null_det,
    input  logic           sat,
    output logic [NPH-1:0] phase,
    output logic [2:0]     code
);
    localparam int TMAX  = (SIG_CYC > BIAS_CYC) ? SIG_CYC : BIAS_CYC;
    localparam int TMR_W = $clog2(TMAX + 1);

    logic [TMR_W-1:0] tmr;
    logic [NPH-1:0]   nxt;
    logic             adv;

    // Decide completion of the current phase and its successor.
    always_comb begin
        nxt = '0;
        adv = 1'b0;
        if (phase[PH_RST]) begin
            adv = start;
            nxt[PH_SIG] = 1'b1;
        end else if (phase[PH_SIG]) begin
            adv = (tmr == TMR_W'(SIG_CYC - 1));
            nxt[PH_BIAS] = 1'b1;
        end else if (phase[PH_BIAS]) begin
            adv = (tmr == TMR_W'(BIAS_CYC - 1));
            nxt[PH_REF1] = 1'b1;
        end else if (phase[PH_REF1]) begin
            adv = sat | null_det;
            if (sat) nxt[PH_STORE] = 1'b1;
            else     nxt[PH_REF2]  = 1'b1;
        end else if (phase[PH_REF2]) begin
            adv = sat | null_det;
            nxt[PH_STORE] = 1'b1;
        end else begin
            adv = 1'b1;
            nxt[PH_RST] = 1'b1;
        end
    end

    // Phase register: step on completion only.
    always_ff @(posedge clk) begin
        if (!rst_n)   phase <= NPH'(1) << PH_RST;
        else if (adv) phase <= nxt;
    end

    // Phase timer: counts within a phase, restarts on every step.
    always_ff @(posedge clk) begin
        if (!rst_n || adv) tmr <= '0;
        else               tmr <= tmr + 1'b1;
    end

    // Analog control code for the active phase.
    always_comb begin
        if      (phase[PH_RST])  code = CODE_RST;
        else if (phase[PH_SIG])  code = CODE_SIG;
        else if (phase[PH_BIAS]) code = CODE_BIAS;
        else if (phase[PH_REF1]) code = CODE_REF1;
        else if (phase[PH_REF2]) code = CODE_REF2;
        else                     code = CODE_IDLE;
    end

    // R1
    onehot_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase) == 1);
    // R2
    legal_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(phase) |->
            (($past(phase[PH_RST])   && phase[PH_SIG])  ||
             ($past(phase[PH_SIG])   && phase[PH_BIAS]) ||
             ($past(phase[PH_BIAS])  && phase[PH_REF1]) ||
             ($past(phase[PH_REF1])  && (phase[PH_REF2] || phase[PH_STORE])) ||
             ($past(phase[PH_REF2])  && phase[PH_STORE]) ||
             ($past(phase[PH_STORE]) && phase[PH_RST])));
endmodule

// File: rtl/adc_delay_cnt.sv
// Settling delay counter: loaded by the processor, drains one per clock in reset.
// Assumes load has priority over decrement.
module adc_delay_cnt #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    input  logic             run,
    output logic             zero
);
    logic [DLY_W-1:0] dly;

    // Load on processor write, otherwise count down while allowed.
    always_ff @(posedge clk) begin
        if (!rst_n)                dly <= '0;
        else if (load)             dly <= load_val;
        else if (run && dly != '0) dly <= dly - 1'b1;
    end

    assign zero = (dly == '0);
endmodule

// File: rtl/adc_main_cnt.sv
// Reference-period counter with selectable saturation point and overrange flag.
// Assumes clr and count enable are never both needed in the same cycle.
module adc_main_cnt #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             clr_ovr,
    input  logic             in_ref,
    input  logic [CNT_W-1:0] term,
    output logic [CNT_W-1:0] count,
    output logic             sat,
    output logic             ovr
);
    assign sat = in_ref && (count >= term);

    // Accumulate reference clocks, holding at the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)      count <= '0;
        else if (in_ref && !sat) count <= count + 1'b1;
    end

    // Overrange flag: set on saturation, cleared by start or control write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || clr_ovr) ovr <= 1'b0;
        else if (sat)                 ovr <= 1'b1;
    end

    // R5
    count_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ref && !clr) |=> $stable(count));
    // R10
    ovr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(in_ref));
endmodule

// File: rtl/adc_seq_ctrl.sv
// Integrating ADC sequence controller top: processor registers, trigger gating,
// data-ready latch, and the phase, delay and count datapaths.
// Assumes all inputs are synchronous to clk.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int RES_BASE = 16,
    parameter int SIG_CYC  = 40,
    parameter int BIAS_CYC = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_sel,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  rd_count,
    input  logic                  trig_int,
    input  logic                  trig_ext,
    input  logic                  trig_cpu,
    input  logic                  null_det,
    output logic [7:0]            phase_oh,
    output logic [2:0]            ana_code,
    output logic [RES_BASE+3:0]   count,
    output logic                  data_ready,
    output logic                  overrange
);
    localparam int CNT_W = RES_BASE + 4;

    logic        ctl_wr, dly_wr, dly_zero, cmd_lat, trig_hit, start, sat, in_ref;
    logic [1:0]  res_sel, res_eff;
    trig_sel_e   trig_sel;
    logic [CNT_W-1:0] term;
    logic        unused_hi;

    assign ctl_wr    = wr_en &&  wr_sel;
    assign dly_wr    = wr_en && !wr_sel;
    assign unused_hi = ^wr_data[DATA_W-1:4];

    // Control register: resolution and trigger source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_sel  <= 2'd0;
            trig_sel <= TRG_INT;
        end else if (ctl_wr) begin
            res_sel  <= wr_data[1:0];
            trig_sel <= trig_sel_e'(wr_data[3:2]);
        end
    end

    // Processor command latch: set by pulse, cleared by control write or use.
    always_ff @(posedge clk) begin
        if (!rst_n || ctl_wr)                  cmd_lat <= 1'b0;
        else if (start && trig_sel == TRG_CPU) cmd_lat <= 1'b0;
        else if (trig_cpu)                     cmd_lat <= 1'b1;
    end

    // Select the active start source.
    always_comb begin
        case (trig_sel)
            TRG_INT: trig_hit = trig_int;
            TRG_EXT: trig_hit = trig_ext;
            TRG_CPU: trig_hit = cmd_lat;
            default: trig_hit = 1'b0;
        endcase
    end

    assign start   = phase_oh[PH_RST] && dly_zero && trig_hit;
    assign in_ref  = phase_oh[PH_REF1] || phase_oh[PH_REF2];
    assign res_eff = (res_sel == 2'd3) ? 2'd2 : res_sel;
    assign term    = (CNT_W'(1) << (RES_BASE + 2 * int'(res_eff))) - 1'b1;

    // Data-ready latch: set when leaving store, cleared by read or control write.
    always_ff @(posedge clk) begin
        if (!rst_n || rd_count || ctl_wr) data_ready <= 1'b0;
        else if (phase_oh[PH_STORE])      data_ready <= 1'b1;
    end

    adc_phase_seq #(.SIG_CYC(SIG_CYC), .BIAS_CYC(BIAS_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .null_det(null_det),
        .sat(sat), .phase(phase_oh), .code(ana_code)
    );

    adc_delay_cnt #(.DLY_W(DATA_W)) u_dly (
        .clk(clk), .rst_n(rst_n), .load(dly_wr), .load_val(wr_data),
        .run(phase_oh[PH_RST]), .zero(dly_zero)
    );

    adc_main_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(start), .clr_ovr(ctl_wr),
        .in_ref(in_ref), .term(term), .count(count), .sat(sat), .ovr(overrange)
    );

    // R6
    hold_while_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_oh[PH_RST] && !dly_zero) |=> phase_oh[PH_RST]);
    // R9
    ready_after_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_ready) |-> $past(phase_oh[PH_STORE]));
    // R2
    spare_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_oh[7:6] == 2'b00);
endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
    localparam int SIGC = 12;
    localparam int BIAC = 6;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        wr_en = 0, wr_sel = 0, rd_count = 0;
    logic [15:0] wr_data = '0;
    logic        trig_int = 0, trig_ext = 0, trig_cpu = 0, null_det = 0;
    logic [7:0]  phase_oh;
    logic [2:0]  ana_code;
    logic [19:0] count;
    logic        data_ready, overrange;
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    adc_seq_ctrl #(.DATA_W(16), .RES_BASE(16), .SIG_CYC(SIGC), .BIAS_CYC(BIAC)) u_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_count(rd_count), .trig_int(trig_int), .trig_ext(trig_ext), .trig_cpu(trig_cpu),
        .null_det(null_det), .phase_oh(phase_oh), .ana_code(ana_code), .count(count),
        .data_ready(data_ready), .overrange(overrange)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    // Waits for the signal phase; returns negedges waited.
    task automatic wait_sig(input int lim, output int n);
        n = 0;
        while (!phase_oh[1] && n < lim) begin @(negedge clk); n++; end
    endtask

    // From the first signal cycle, run a conversion with n1/n2 reference clocks.
    task automatic run_conv(input int n1, input int n2);
        int len;
        chk("R3 sig code", ana_code, 1);
        len = 0; while (phase_oh[1] && len < 100) begin @(negedge clk); len++; end
        chk("R4 sig length", len, SIGC);
        chk("R2 bias follows", phase_oh, 8'h04);
        chk("R3 bias code", ana_code, 2);
        len = 0; while (phase_oh[2] && len < 100) begin @(negedge clk); len++; end
        chk("R4 bias length", len, BIAC);
        chk("R2 ref1 follows", phase_oh, 8'h08);
        chk("R3 ref1 code", ana_code, 3);
        repeat (n1 - 1) @(negedge clk);
        null_det = 1; @(negedge clk); null_det = 0;
        chk("R5 ref2 after null", phase_oh, 8'h10);
        chk("R3 ref2 code", ana_code, 4);
        repeat (n2 - 1) @(negedge clk);
        null_det = 1; @(negedge clk); null_det = 0;
        chk("R2 store phase", phase_oh, 8'h20);
        chk("R3 store code", ana_code, 7);
        chk("R9 not ready in store", data_ready, 0);
        @(negedge clk);
        chk("R9 ready set", data_ready, 1);
        chk("R2 back to reset", phase_oh, 8'h01);
        chk("R5 count", count, n1 + n2);
        chk("R10 no overrange", overrange, 0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1 reset phase", phase_oh, 8'h01);
        chk("R3 reset code", ana_code, 0);
        chk("R1 reset count", count, 0);
        chk("R1 reset ready", data_ready, 0);
        chk("R1 reset ovr", overrange, 0);
        rst_n = 1;
        repeat (4) @(negedge clk);
        chk("R7 no trigger no start", phase_oh, 8'h01);
    endtask

    task automatic t_delay;
        int n;
        wr(0, 16'd10);
        trig_int = 1;
        repeat (5) @(negedge clk);
        chk("R6 held by delay", phase_oh, 8'h01);
        wait_sig(50, n);
        chk("R6 start after delay", n + 5, 11);
        trig_int = 0;
        run_conv(4, 7);
    endtask

    task automatic t_read;
        @(negedge clk); rd_count = 1; @(negedge clk); rd_count = 0;
        chk("R9 read clears ready", data_ready, 0);
        chk("R5 count held after read", count, 11);
    endtask

    task automatic t_ext;
        int n;
        wr(1, 16'h0004);
        trig_int = 1; repeat (4) @(negedge clk); trig_int = 0;
        chk("R7 internal ignored", phase_oh, 8'h01);
        trig_ext = 1; @(negedge clk); trig_ext = 0;
        chk("R7 external starts", phase_oh, 8'h02);
        chk("R5 count cleared at start", count, 0);
        run_conv(1, 3);
    endtask

    task automatic t_cpu;
        int n;
        @(negedge clk); trig_cpu = 1; @(negedge clk); trig_cpu = 0;
        wr(1, 16'h0008);
        chk("R9 control write clears ready", data_ready, 0);
        repeat (5) @(negedge clk);
        chk("R8 latch cleared by control", phase_oh, 8'h01);
        trig_cpu = 1; @(negedge clk); trig_cpu = 0;
        wait_sig(10, n);
        chk("R8 cpu latch start", n, 1);
        run_conv(9, 2);
        repeat (4) @(negedge clk);
        chk("R8 latch consumed", phase_oh, 8'h01);
    endtask

    task automatic t_ovr;
        int n;
        wr(1, 16'h0000);
        trig_int = 1; @(negedge clk); trig_int = 0;
        n = 0;
        while (!data_ready && n < 80000) begin @(negedge clk); n++; end
        chk("R10 saturated count", count, 65535);
        chk("R10 overrange set", overrange, 1);
        chk("R10 ready with overrange", data_ready, 1);
        wr(1, 16'h0000);
        chk("R10 control clears ovr", overrange, 0);
        chk("R10 count kept", count, 65535);
    endtask

    initial begin
        t_reset;
        t_delay;
        t_read;
        t_ext;
        t_cpu;
        t_ovr;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule